// File: doc/BRIEF.md
# Fiber Link Fault Monitor

This block watches one 100 Mbps fiber port for link faults. There are two fault sources. The first is the signal-detect output of the local optical transceiver, which goes low when the optical signal is lost. The second is the far end fault pattern, found in the bit stream received after NRZI decoding. The two sources are ORed into one sticky status flag that clears when software reads it. The same fault decides the link-up output, unless a forced-link configuration bit holds the link up.

When the link goes from up to down, an interrupt request is raised and held until the status word is read. While the local optical signal is missing and the fault-send enable is set, the transmit selector picks the far end fault pattern instead of idle code. A small synchronous register port carries the two configuration bits and the status word. The fiber path runs at 100 Mbps only. There is no 10 Mbps fiber mode.

Top module: `fiber_fault_mon`

## Requirements
- R1: After reset, with signal detect high and no pattern received, link_up_o is 1 within three cycles, irq_o and tx_fef_o are 0, and the configuration reads back as 0.
- R2: sig_det_i goes through a two-stage synchronizer. A change on it reaches link_up_o, tx_fef_o and the status flag at the third rising edge after the change.
- R3: A far end fault is declared once the receiver has seen, on valid bits, three frames in a row of exactly 84 ones followed by one zero. The fault is visible one cycle after the zero that ends the third frame. Two frames alone do not declare it.
- R4: A frame whose run of ones is shorter or longer than 84 resets the frame count and clears a declared far end fault. A run that is too long clears it on the 85th one.
- R5: Status bit 0 is set whenever a local fault or a far end fault is present. It stays set until a status read. If a fault is present in the cycle of the read, the bit remains set.
- R6: Either fault drives link_up_o to 0 unless config bit 0 (forced link) is 1. In that case link_up_o stays 1.
- R7: irq_o rises only when link_up_o goes from 1 to 0. It is held until a status read. When a link drop and a status read fall in the same cycle, the interrupt stays set.
- R8: tx_fef_o (1 = send far end fault pattern, 0 = send idle) is 1 exactly when a synchronized local signal loss is present and config bit 1 is 1. A far end fault alone never sets it.
- R9: Address 0 is the configuration register (read/write, bit 0 forced link, bit 1 fault-send enable). Address 1 is the status word (bit 0 sticky fault, bit 1 link up, bit 2 local fault now, bit 3 far end fault now). Read data is registered and appears one cycle after the read strobe, holding the values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_det_i | input | 1 | Optical signal detect, 1 = signal present |
| rx_valid_i | input | 1 | Qualifies rx_bit_i |
| rx_bit_i | input | 1 | Received bit after NRZI decoding |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| link_up_o | output | 1 | Link status |
| irq_o | output | 1 | Link-down interrupt request |
| tx_fef_o | output | 1 | Transmit selector, 1 = far end fault pattern |

## Verification
Two pairs of events can land on the same clock edge. A status read can meet a new link drop, and it can also meet a newly arriving fault. The bench lowers signal detect and then places the status read strobe so that it samples on the exact edge where the synchronized loss first reaches the fault logic. It expects irq_o to stay 1 and the sticky flag to read 0 in that read and 1 in the next. A third check reads the status while a fault is still present and expects the flag to remain set.

// File: rtl/fiber_fault_pkg.sv
package fiber_fault_pkg;
  localparam int CFG_ADDR  = 0;
  localparam int STAT_ADDR = 1;
  // configuration bits
  localparam int CFG_FORCE_BIT = 0;
  localparam int CFG_FEF_BIT   = 1;
  // status word bits
  localparam int ST_STICKY_BIT = 0;
  localparam int ST_LINK_BIT   = 1;
  localparam int ST_LOCAL_BIT  = 2;
  localparam int ST_REMOTE_BIT = 3;
endpackage

// File: rtl/fiber_sd_sync.sv
module fiber_sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fiber_fef_detect.sv
module fiber_fef_detect #(
  parameter int ONES_LEN = 84,
  parameter int REPEAT   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic fef_o
);
  localparam int CW = $clog2(ONES_LEN + 2);
  localparam int RW = $clog2(REPEAT + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(ONES_LEN);
  localparam logic [CW-1:0] RUN_OVER = CW'(ONES_LEN + 1);
  localparam logic [RW-1:0] REP_MAX  = RW'(REPEAT);

  logic [CW-1:0] run_q;
  logic [RW-1:0] rep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      rep_q <= '0;
    end else if (bit_valid_i) begin
      if (bit_i) begin
        if (run_q == RUN_MAX) begin
          run_q <= RUN_OVER;   // run too long: pattern broken
          rep_q <= '0;
        end else if (run_q < RUN_MAX) begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
        if (run_q == RUN_MAX) begin
          if (rep_q != REP_MAX) rep_q <= rep_q + 1'b1;
        end else begin
          rep_q <= '0;
        end
      end
    end
  end

  assign fef_o = (rep_q == REP_MAX);
endmodule

// File: rtl/fiber_fault_ctrl.sv
module fiber_fault_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic local_flt_i,
  input  logic remote_flt_i,
  input  logic force_link_i,
  input  logic fef_en_i,
  input  logic stat_rd_i,
  output logic link_up_o,
  output logic irq_o,
  output logic tx_fef_o,
  output logic sticky_o
);
  logic any_flt;
  logic link_nxt;
  logic drop;

  assign any_flt  = local_flt_i | remote_flt_i;
  assign link_nxt = force_link_i | ~any_flt;
  assign drop     = link_up_o & ~link_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_up_o <= 1'b0;
      irq_o     <= 1'b0;
      tx_fef_o  <= 1'b0;
      sticky_o  <= 1'b0;
    end else begin
      link_up_o <= link_nxt;
      irq_o     <= drop | (irq_o & ~stat_rd_i);
      sticky_o  <= any_flt | (sticky_o & ~stat_rd_i);
      tx_fef_o  <= local_flt_i & fef_en_i;
    end
  end
endmodule

// File: rtl/fiber_fault_mon.sv
module fiber_fault_mon
  import fiber_fault_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int ONES_LEN = 84,
  parameter int REPEAT   = 3,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_det_i,
  input  logic              rx_valid_i,
  input  logic              rx_bit_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              link_up_o,
  output logic              irq_o,
  output logic              tx_fef_o
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic [DATA_W-1:0] cfg_q;
  logic              sd_sync;
  logic              remote_flt;
  logic              sticky;
  logic              stat_rd;
  logic [DATA_W-1:0] status_w;

  fiber_sd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_i(sig_det_i), .sync_o(sd_sync)
  );

  fiber_fef_detect #(.ONES_LEN(ONES_LEN), .REPEAT(REPEAT)) u_fef (
    .clk(clk), .rst(rst), .bit_valid_i(rx_valid_i), .bit_i(rx_bit_i),
    .fef_o(remote_flt)
  );

  assign stat_rd = reg_rd_i & (reg_addr_i == A_STAT);

  fiber_fault_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .local_flt_i(~sd_sync), .remote_flt_i(remote_flt),
    .force_link_i(cfg_q[CFG_FORCE_BIT]), .fef_en_i(cfg_q[CFG_FEF_BIT]),
    .stat_rd_i(stat_rd),
    .link_up_o(link_up_o), .irq_o(irq_o), .tx_fef_o(tx_fef_o),
    .sticky_o(sticky)
  );

  always_comb begin
    status_w                = '0;
    status_w[ST_STICKY_BIT] = sticky;
    status_w[ST_LINK_BIT]   = link_up_o;
    status_w[ST_LOCAL_BIT]  = ~sd_sync;
    status_w[ST_REMOTE_BIT] = remote_flt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      reg_rdata_o <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == A_CFG) cfg_q <= reg_wdata_i;
      if (reg_rd_i) begin
        if (reg_addr_i == A_CFG)       reg_rdata_o <= cfg_q;
        else if (reg_addr_i == A_STAT) reg_rdata_o <= status_w;
        else                           reg_rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/fiber_fault_mon_chk.sv
module fiber_fault_mon_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              link_up_o,
  input logic              irq_o,
  input logic              tx_fef_o,
  input logic              cfg_force,
  input logic              cfg_fef_en,
  input logic              sticky
);
  logic stat_rd;
  assign stat_rd = reg_rd_i && (reg_addr_i == ADDR_W'(1));

  // R7: interrupt rises only together with a link drop
  a_r7_irq_on_drop: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(link_up_o) && !link_up_o));

  // R7: interrupt held until a status read
  a_r7_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !stat_rd) |=> irq_o);

  // R6: forced link keeps link up
  a_r6_force_link: assert property (@(posedge clk) disable iff (rst)
    cfg_force |=> link_up_o);

  // R8: no fault pattern sent without the enable
  a_r8_tx_needs_en: assert property (@(posedge clk) disable iff (rst)
    !cfg_fef_en |=> !tx_fef_o);

  // R5: sticky flag only clears on a status read
  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (sticky && !stat_rd) |=> sticky);
endmodule

bind fiber_fault_mon fiber_fault_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .link_up_o(link_up_o), .irq_o(irq_o), .tx_fef_o(tx_fef_o),
  .cfg_force(cfg_q[0]), .cfg_fef_en(cfg_q[1]), .sticky(sticky)
);

// File: tb/fiber_fault_mon_tb_top.sv
module fiber_fault_mon_tb_top;
  localparam int AW = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sig_det = 1'b1;
  logic          rx_valid = 1'b0;
  logic          rx_bit = 1'b0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          link_up, irq, tx_fef;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fiber_fault_mon dut_i (
    .clk(clk), .rst(rst), .sig_det_i(sig_det), .rx_valid_i(rx_valid),
    .rx_bit_i(rx_bit), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .link_up_o(link_up),
    .irq_o(irq), .tx_fef_o(tx_fef)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(int a, int d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(int a, output int d);
    @(negedge clk);
    rd = 1'b1; addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    d = int'(rdata);
  endtask

  task automatic send_frame(int ones);
    for (int i = 0; i < ones; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_bit = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 1'b1; rx_bit = 1'b0;
    @(posedge clk);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    int d;
    wait_cyc(3);
    chk("R1 link after reset", link_up, 1);
    chk("R1 irq after reset", irq, 0);
    chk("R1 tx after reset", tx_fef, 0);
    reg_read(0, d);
    chk("R1 cfg after reset", d, 0);
    reg_read(1, d);
    chk("R1 status after reset", d, 2);
  endtask

  task automatic t_local_fault;
    int d;
    @(negedge clk); sig_det = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 link before third edge", link_up, 1);
    wait_cyc(1);
    chk("R2 link at third edge", link_up, 0);
    chk("R7 irq on drop", irq, 1);
    chk("R8 tx idle when disabled", tx_fef, 0);
    wait_cyc(3);
    chk("R7 irq held", irq, 1);
    reg_read(1, d);
    chk("R9 status during local fault", d, 5);
    chk("R7 irq cleared by read", irq, 0);
    reg_read(1, d);
    chk("R5 sticky while fault persists", d & 1, 1);
    @(negedge clk); sig_det = 1'b1;
    wait_cyc(4);
    chk("R6 link back up", link_up, 1);
    chk("R7 no irq on link up", irq, 0);
    reg_read(1, d);
    chk("R5 sticky after fault gone", d & 1, 1);
    reg_read(1, d);
    chk("R5 sticky cleared", d, 2);
  endtask

  task automatic t_forced;
    int d;
    reg_write(0, 1);
    @(negedge clk); sig_det = 1'b0;
    wait_cyc(5);
    chk("R6 forced link stays up", link_up, 1);
    chk("R7 no irq when forced", irq, 0);
    @(negedge clk); sig_det = 1'b1;
    wait_cyc(4);
    reg_read(1, d);
    chk("R5 fault latched when forced", d & 1, 1);
    reg_read(1, d);
    reg_write(0, 0);
  endtask

  task automatic t_fef_send;
    int d;
    reg_write(0, 2);
    reg_read(0, d);
    chk("R9 cfg readback", d, 2);
    @(negedge clk); sig_det = 1'b0;
    wait_cyc(3);
    chk("R8 fault pattern sent", tx_fef, 1);
    chk("R6 link down with enable", link_up, 0);
    @(negedge clk); sig_det = 1'b1;
    wait_cyc(3);
    chk("R8 back to idle", tx_fef, 0);
    reg_read(1, d);
    reg_read(1, d);
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_remote;
    int d;
    send_frame(84);
    send_frame(84);
    wait_cyc(2);
    chk("R3 two frames no fault", link_up, 1);
    send_frame(84);
    wait_cyc(1);
    chk("R3 three frames drop link", link_up, 0);
    chk("R8 remote fault no tx", tx_fef, 0);
    reg_read(1, d);
    chk("R9 status remote", d, 9);
    send_frame(83);
    wait_cyc(1);
    chk("R4 short run clears", link_up, 1);
    send_frame(84); send_frame(84); send_frame(84);
    wait_cyc(1);
    chk("R3 fault again", link_up, 0);
    for (int i = 0; i < 85; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_bit = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 1'b0;
    wait_cyc(1);
    chk("R4 long run clears", link_up, 1);
    send_frame(0);
    reg_read(1, d);
    reg_read(1, d);
    chk("R5 cleared after remote", d, 2);
    reg_write(0, 0);
  endtask

  task automatic t_collision;
    int d;
    chk("R7 irq idle before collision", irq, 0);
    @(negedge clk); sig_det = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd = 1'b1; addr = AW'(1);
    @(posedge clk);
    @(negedge clk); rd = 1'b0;
    chk("R7 drop beats read", irq, 1);
    chk("R5 read saw pre-edge flag", int'(rdata) & 1, 0);
    reg_read(1, d);
    chk("R5 new fault beats clear", d & 1, 1);
    @(negedge clk); sig_det = 1'b1;
    wait_cyc(4);
    reg_read(1, d);
    reg_read(1, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_local_fault();
    t_forced();
    t_fef_send();
    t_remote();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule